// File: doc/BRIEF.md
# Stuttering State Machine with a Pipelined Slow Path

This block is a small synchronous state machine. Its next-state logic is split in two. A select predicate picks either a fast function, which is wired straight into the state register, or a slow function, which has one extra pipeline register in its path. A slow selection takes two cycles. In the first cycle the slow result is captured and the main state register is held. In the second cycle that result is written into the state. The machine therefore stutters: it computes the same sequence of states as an unpipelined machine and only inserts stall cycles.

The state is made of four parts:
- an accumulator, which is the observable result;
- an operand;
- a remaining-step count;
- a halt bit.

A synchronous load writes the initial state, including the data arguments, and overrides everything else. A clock enable gates all progress.

An observer labels the outputs:
- `result_o` always shows the accumulator.
- `result_valid_o` marks each cycle in which a step commits, with the state being stepped on `result_o`.
- `stutter_o` flags the first cycle of a slow evaluation, so that the state shown in that cycle is not reported twice.
- `halted_o` is the halt bit.

The observer flags are plain one-cycle indications with no ready input. A consumer must accept every valid cycle, and it can stall the machine only by lowering `run_en_i`.

Top module: `ssm_stutter_fsm`

## Requirements
- R1: After reset `halted_o` is 1, `result_o` is 0, and `result_valid_o` and `stutter_o` are 0.
- R2: A cycle with `load_i` high writes `init_acc_i`, `init_arg_i` and `init_cnt_i` at the next edge, whatever `run_en_i` is. After that edge `result_o` equals `init_acc_i`, and `halted_o` is 1 exactly when `init_cnt_i` is 0.
- R3: With the default `SEL_MODE` of 0, the slow path is chosen when bit 0 of the accumulator is 1. With `SEL_MODE` 1, it is chosen when the XOR reduction of accumulator XOR operand is 1.
- R4: A fast step happens in one cycle that is running (run enabled, no load, not halted). In that cycle `result_valid_o` is 1 and `result_o` shows the current accumulator. After the edge the accumulator is accumulator + operand modulo 2^DATA_W, and the count is one lower.
- R5: A slow step takes two running cycles.
  - First cycle: `stutter_o` is 1, `result_valid_o` is 0, and the state is unchanged after the edge.
  - Second cycle: `result_valid_o` is 1 and `result_o` still shows the same accumulator.
  - After the second edge the accumulator is the slow function of accumulator and operand, and the count is one lower.
  - The slow function repeats SLOW_ROUNDS times: x = rotate-left-by-1((5*x) XOR operand), with x starting at the accumulator and all arithmetic modulo 2^DATA_W.
- R6: `stutter_o` is never high in two consecutive cycles, and `result_valid_o` is 0 in any cycle where `stutter_o` is 1.
- R7: When a step brings the count to 0, `halted_o` rises. From then until the next load, the state holds and `result_valid_o` and `stutter_o` stay 0.
- R8: While `run_en_i` is 0 and `load_i` is 0, the state does not change and `result_valid_o` and `stutter_o` are 0. A slow result already captured is kept and is committed in the first running cycle after `run_en_i` returns.
- R9: A load in the cycle after a stutter discards the captured slow result. The next step is evaluated from the freshly loaded state.
- R10: Across a whole run from load to halt, the values on `result_o` in the valid cycles, followed by the value held at halt, equal the state sequence of an unpipelined machine stepped `init_cnt_i` times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Synchronous load of the initial state; overrides all else |
| init_acc_i | input | DATA_W | Initial accumulator |
| init_arg_i | input | DATA_W | Operand held for the whole run |
| init_cnt_i | input | CNT_W | Number of steps to run |
| run_en_i | input | 1 | Clock enable for progress |
| result_o | output | DATA_W | Current accumulator |
| result_valid_o | output | 1 | A step commits this cycle; result_o is the state being stepped |
| halted_o | output | 1 | Halt bit of the state |
| stutter_o | output | 1 | First cycle of a slow evaluation |

## Verification
The assertions assume that the inputs are stable around the sampling edge and that `load_i` and `run_en_i` are known (never X) after reset. Their stability checks are conditioned on `load_i` being low, because a load may rewrite the state at any edge. The stimulus changes inputs only just after a rising edge. It keeps counts at 12 or below so that every run can be compared against a precomputed reference sequence. It mixes enable dropouts and mid-run reloads into the random runs, including reloads landing right after a stutter.

// File: rtl/ssm_pkg.sv
package ssm_pkg;

  // Decoded role of the current cycle.
  typedef enum logic [1:0] {
    PATH_IDLE   = 2'd0,
    PATH_FAST   = 2'd1,
    PATH_LAUNCH = 2'd2,
    PATH_FINISH = 2'd3
  } ssm_path_e;

  // Predicate variants chosen by parameter.
  localparam int SEL_BIT0   = 0;
  localparam int SEL_PARITY = 1;

endpackage

// File: rtl/ssm_select.sv
module ssm_select #(
  parameter int DATA_W   = 16,
  parameter int SEL_MODE = 0
) (
  input  logic [DATA_W-1:0] acc_i,
  input  logic [DATA_W-1:0] arg_i,
  output logic              slow_o
);
  import ssm_pkg::*;

  generate
    if (SEL_MODE == SEL_PARITY) begin : g_parity
      assign slow_o = ^(acc_i ^ arg_i);
    end else begin : g_bit0
      logic unused_arg;
      assign unused_arg = ^arg_i;
      assign slow_o     = acc_i[0];
    end
  endgenerate

endmodule

// File: rtl/ssm_fast_path.sv
module ssm_fast_path #(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] acc_i,
  input  logic [DATA_W-1:0] arg_i,
  output logic [DATA_W-1:0] acc_o
);

  assign acc_o = acc_i + arg_i;

endmodule

// File: rtl/ssm_slow_path.sv
module ssm_slow_path #(
  parameter int DATA_W      = 16,
  parameter int SLOW_ROUNDS = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] acc_i,
  input  logic [DATA_W-1:0] arg_i,
  input  logic              launch_i,
  input  logic              finish_i,
  input  logic              flush_i,
  output logic              busy_o,
  output logic [DATA_W-1:0] acc_o
);

  localparam int NSTAGE = SLOW_ROUNDS + 1;

  logic [DATA_W-1:0] chain [NSTAGE];
  logic [DATA_W-1:0] pipe_q;
  logic              busy_q;

  assign chain[0] = acc_i;

  // Unrolled mixing rounds: x = rotl1((5x) ^ arg).
  for (genvar r = 0; r < SLOW_ROUNDS; r++) begin : g_round
    logic [DATA_W-1:0] mul5;
    logic [DATA_W-1:0] mixed;
    assign mul5         = chain[r] + (chain[r] << 2);
    assign mixed        = mul5 ^ arg_i;
    assign chain[r + 1] = {mixed[DATA_W-2:0], mixed[DATA_W-1]};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pipe_q <= '0;
      busy_q <= 1'b0;
    end else if (flush_i) begin
      busy_q <= 1'b0;
    end else if (launch_i) begin
      pipe_q <= chain[SLOW_ROUNDS];
      busy_q <= 1'b1;
    end else if (finish_i) begin
      busy_q <= 1'b0;
    end
  end

  assign busy_o = busy_q;
  assign acc_o  = pipe_q;

endmodule

// File: rtl/ssm_observer.sv
module ssm_observer #(
  parameter int DATA_W = 16
) (
  input  ssm_pkg::ssm_path_e path_i,
  input  logic [DATA_W-1:0]  acc_i,
  input  logic               halt_i,
  output logic [DATA_W-1:0]  result_o,
  output logic               result_valid_o,
  output logic               halted_o,
  output logic               stutter_o
);
  import ssm_pkg::*;

  // The state shown during a launch cycle reappears in the finish cycle;
  // only the finish cycle reports it.
  assign stutter_o      = (path_i == PATH_LAUNCH);
  assign result_valid_o = !stutter_o &&
                          ((path_i == PATH_FAST) || (path_i == PATH_FINISH));
  assign result_o       = acc_i;
  assign halted_o       = halt_i;

endmodule

// File: rtl/ssm_stutter_fsm.sv
module ssm_stutter_fsm #(
  parameter int DATA_W      = 16,
  parameter int CNT_W       = 6,
  parameter int SLOW_ROUNDS = 2,
  parameter int SEL_MODE    = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] init_acc_i,
  input  logic [DATA_W-1:0] init_arg_i,
  input  logic [CNT_W-1:0]  init_cnt_i,
  input  logic              run_en_i,
  output logic [DATA_W-1:0] result_o,
  output logic              result_valid_o,
  output logic              halted_o,
  output logic              stutter_o
);
  import ssm_pkg::*;

  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [DATA_W-1:0] acc_q, arg_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              halt_q;

  logic              sel_slow;
  logic              busy;
  logic [DATA_W-1:0] fast_acc, slow_acc, next_acc;
  logic              active, commit;
  ssm_path_e         path;

  ssm_select #(.DATA_W(DATA_W), .SEL_MODE(SEL_MODE)) u_sel (
    .acc_i (acc_q),
    .arg_i (arg_q),
    .slow_o(sel_slow)
  );

  ssm_fast_path #(.DATA_W(DATA_W)) u_fast (
    .acc_i(acc_q),
    .arg_i(arg_q),
    .acc_o(fast_acc)
  );

  ssm_slow_path #(.DATA_W(DATA_W), .SLOW_ROUNDS(SLOW_ROUNDS)) u_slow (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .acc_i   (acc_q),
    .arg_i   (arg_q),
    .launch_i(path == PATH_LAUNCH),
    .finish_i(path == PATH_FINISH),
    .flush_i (load_i),
    .busy_o  (busy),
    .acc_o   (slow_acc)
  );

  // Cycle role decode: a pending slow result always finishes before the
  // predicate is consulted again.
  always_comb begin
    active = run_en_i && !load_i && !halt_q;
    if (!active)        path = PATH_IDLE;
    else if (busy)      path = PATH_FINISH;
    else if (sel_slow)  path = PATH_LAUNCH;
    else                path = PATH_FAST;
  end

  assign commit   = (path == PATH_FAST) || (path == PATH_FINISH);
  assign next_acc = (path == PATH_FINISH) ? slow_acc : fast_acc;

  // Main state register; its enable is low during a launch cycle.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q  <= '0;
      arg_q  <= '0;
      cnt_q  <= '0;
      halt_q <= 1'b1;
    end else if (load_i) begin
      acc_q  <= init_acc_i;
      arg_q  <= init_arg_i;
      cnt_q  <= init_cnt_i;
      halt_q <= (init_cnt_i == '0);
    end else if (commit) begin
      acc_q  <= next_acc;
      cnt_q  <= cnt_q - CNT_ONE;
      halt_q <= (cnt_q == CNT_ONE);
    end
  end

  ssm_observer #(.DATA_W(DATA_W)) u_obs (
    .path_i        (path),
    .acc_i         (acc_q),
    .halt_i        (halt_q),
    .result_o      (result_o),
    .result_valid_o(result_valid_o),
    .halted_o      (halted_o),
    .stutter_o     (stutter_o)
  );

endmodule

// File: rtl/ssm_stutter_fsm_chk.sv
module ssm_stutter_fsm_chk #(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              load_i,
  input logic [DATA_W-1:0] init_acc_i,
  input logic [CNT_W-1:0]  init_cnt_i,
  input logic              run_en_i,
  input logic [DATA_W-1:0] result_o,
  input logic              result_valid_o,
  input logic              halted_o,
  input logic              stutter_o
);

  assert_load_value_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (result_o == $past(init_acc_i)) &&
               (halted_o == ($past(init_cnt_i) == '0)));

  assert_stall_holds_state_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stutter_o |=> $stable(result_o) && !halted_o);

  assert_single_stutter_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stutter_o |=> !stutter_o);

  assert_no_double_report_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stutter_o |-> !result_valid_o);

  assert_halt_sticks_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halted_o && !load_i) |=> halted_o && $stable(result_o));

  assert_halt_quiet_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halted_o && !load_i |-> !result_valid_o && !stutter_o);

  assert_enable_freeze_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_en_i && !load_i) |=> $stable(result_o) && $stable(halted_o));

  assert_enable_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_en_i |-> !result_valid_o && !stutter_o);

endmodule

bind ssm_stutter_fsm ssm_stutter_fsm_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .load_i        (load_i),
  .init_acc_i    (init_acc_i),
  .init_cnt_i    (init_cnt_i),
  .run_en_i      (run_en_i),
  .result_o      (result_o),
  .result_valid_o(result_valid_o),
  .halted_o      (halted_o),
  .stutter_o     (stutter_o)
);

// File: tb/ssm_stutter_fsm_test.sv
`timescale 1ns/1ps
module ssm_stutter_fsm_test;
  localparam int DW = 16;
  localparam int CW = 6;
  localparam int ROUNDS = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          load = 1'b0;
  logic [DW-1:0] i_acc = '0, i_arg = '0;
  logic [CW-1:0] i_cnt = '0;
  logic          run = 1'b0;
  logic [DW-1:0] result;
  logic          valid, halted, stutter;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  ssm_stutter_fsm #(.DATA_W(DW), .CNT_W(CW), .SLOW_ROUNDS(ROUNDS), .SEL_MODE(0)) uut (
    .clk_i(clk), .rst_ni(rst_n), .load_i(load), .init_acc_i(i_acc),
    .init_arg_i(i_arg), .init_cnt_i(i_cnt), .run_en_i(run),
    .result_o(result), .result_valid_o(valid), .halted_o(halted),
    .stutter_o(stutter)
  );

  // Reference functions from the requirements.
  function automatic logic [DW-1:0] f_fast(logic [DW-1:0] a, logic [DW-1:0] g);
    return a + g;
  endfunction

  function automatic logic [DW-1:0] f_slow(logic [DW-1:0] a, logic [DW-1:0] g);
    logic [DW-1:0] x = a;
    for (int r = 0; r < ROUNDS; r++) begin
      x = (x * 5) ^ g;
      x = {x[DW-2:0], x[DW-1]};
    end
    return x;
  endfunction

  function automatic bit f_sel(logic [DW-1:0] a);
    return a[0];
  endfunction

  // Cycle model state.
  logic [DW-1:0] m_acc = '0, m_arg = '0, m_pipe = '0;
  int            m_cnt = 0;
  bit            m_halt = 1'b1, m_busy = 1'b0;
  // Unpipelined reference sequence.
  logic [DW-1:0] ref_seq [16];
  int            ref_n = 0, seq_idx = 0;
  bit            final_done = 1'b1;

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  // One cycle: drive inputs after the edge, check at the falling edge,
  // then advance the model as the next rising edge will.
  task automatic tick(bit ld, logic [DW-1:0] a, logic [DW-1:0] g, int c, bit en);
    bit act_c, e_stut, e_valid;
    @(posedge clk); #1;
    load = ld; i_acc = a; i_arg = g; i_cnt = CW'(c); run = en;
    @(negedge clk);
    act_c   = en && !ld && !m_halt;
    e_stut  = act_c && !m_busy && f_sel(m_acc);
    e_valid = act_c && (m_busy || !f_sel(m_acc));
    check(result == m_acc, "R4/R5 result", 32'(result), 32'(m_acc));
    check(halted == m_halt, "R7 halted", 32'(halted), 32'(m_halt));
    check(stutter == e_stut, "R6 stutter", 32'(stutter), 32'(e_stut));
    check(valid == e_valid, "R8 valid", 32'(valid), 32'(e_valid));
    if (valid && seq_idx < 16) begin
      check(result == ref_seq[seq_idx], "R10 sequence", 32'(result), 32'(ref_seq[seq_idx]));
      seq_idx++;
    end
    if (halted && !final_done && !ld) begin
      check(result == ref_seq[ref_n] && seq_idx == ref_n, "R10 final",
            32'(result), 32'(ref_seq[ref_n]));
      final_done = 1'b1;
    end
    if (ld) begin
      m_acc = a; m_arg = g; m_cnt = c; m_halt = (c == 0); m_busy = 1'b0;
      ref_seq[0] = a;
      for (int k = 0; k < c; k++)
        ref_seq[k+1] = f_sel(ref_seq[k]) ? f_slow(ref_seq[k], g) : f_fast(ref_seq[k], g);
      ref_n = c; seq_idx = 0; final_done = 1'b0;
    end else if (act_c) begin
      if (m_busy) begin
        m_acc = m_pipe; m_busy = 1'b0; m_cnt--; m_halt = (m_cnt == 0);
      end else if (f_sel(m_acc)) begin
        m_pipe = f_slow(m_acc, m_arg); m_busy = 1'b1;
      end else begin
        m_acc = f_fast(m_acc, m_arg); m_cnt--; m_halt = (m_cnt == 0);
      end
    end
  endtask

  task automatic idle(int n, bit en);
    for (int i = 0; i < n; i++) tick(1'b0, '0, '0, 0, en);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check(halted == 1'b1, "R1 halted", 32'(halted), 1);
    check(result == '0, "R1 result", 32'(result), 0);
    check(!valid && !stutter, "R1 flags", {valid, stutter}, 0);

    // R2, R4: even accumulator and even operand keep to the fast path
    tick(1'b1, 16'h0002, 16'h0004, 3, 1'b0);
    idle(5, 1'b1);
    // R3, R5: odd accumulator selects the slow path
    tick(1'b1, 16'h0001, 16'h0002, 3, 1'b1);
    idle(10, 1'b1);
    // R8: enable dropped while a slow result is pending
    tick(1'b1, 16'h0003, 16'h0010, 2, 1'b0);
    tick(1'b0, '0, '0, 0, 1'b1);          // launch (stutter)
    idle(3, 1'b0);                         // frozen with pending result
    idle(6, 1'b1);
    // R9: reload right after a stutter discards the pending result
    tick(1'b1, 16'h0005, 16'h0007, 4, 1'b1);
    tick(1'b0, '0, '0, 0, 1'b1);          // launch
    tick(1'b1, 16'h0008, 16'h0002, 1, 1'b1);
    idle(4, 1'b1);
    // R7: zero count halts at once
    tick(1'b1, 16'hBEEF, 16'h1234, 0, 1'b1);
    idle(3, 1'b1);

    // Random runs with enable dropouts and occasional reloads.
    void'($urandom(32'h5eed_1234));
    for (int t = 0; t < 400; t++) begin
      int c = int'($urandom_range(0, 12));
      tick(1'b1, DW'($urandom), DW'($urandom), c, ($urandom_range(0, 3) != 0));
      for (int k = 0; k < 40 && !(m_halt); k++) begin
        if ($urandom_range(0, 49) == 0)
          tick(1'b1, DW'($urandom), DW'($urandom), int'($urandom_range(1, 12)), 1'b1);
        else
          tick(1'b0, '0, '0, 0, ($urandom_range(0, 3) != 0));
      end
      idle(1, 1'b1);
    end

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL R10 watchdog actual=running expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end

endmodule